// File: doc/BRIEF.md
# ADC Sample Span Monitor

This peripheral sits on an APB bus and watches up to four ADC sample streams that run on the bus clock. For each channel it keeps the smallest and the largest sample seen since the last restart. It also makes the live sample readable. Software reads the live samples and the per-channel span words, and starts a new observation window by writing a one to a clear command register.

The tracking does not begin from fixed extreme constants. On reset release, and on every clear, both the minimum and the maximum of every channel are loaded with the sample present at that moment. From then on, the minimum moves only when a strictly smaller sample arrives, and the maximum moves only when a strictly larger one arrives. A build-time parameter selects how samples are ordered: as two's-complement values or as unsigned offset-binary values. Channels beyond the built channel count read back as zero.

Top module: `span_watch`

## Requirements
- R1: While `rst_n` is low, `pready` and `prdata` are 0.
- R2: Reset `rst_n` is released through a two-stage synchronizer. On the first clock edge after the internal reset is released, the minimum and the maximum of every implemented channel take the sample present at that edge.
- R3: In all other cycles, a channel's minimum is replaced only by a sample that is strictly below it, and its maximum only by a sample strictly above it. Equal samples change nothing.
- R4: With `SIGNED_CMP`=1, samples are ordered as two's-complement `SMP_W`-bit values, so 14'h2000 is the lowest and 14'h1FFF the highest. With `SIGNED_CMP`=0, they are ordered as unsigned values, so 14'h0000 is the lowest and 14'h3FFF the highest.
- R5: An APB write to byte offset 0x28C with `pwdata[0]`=1 raises an internal clear strobe for exactly one cycle. On the next clock edge after the write's setup edge, every channel's minimum and maximum take the sample present at that edge. After that, tracking resumes under R3.
- R6: A write to 0x28C with `pwdata[0]`=0 does not disturb the tracked values.
- R7: A read of offset 0x290 + 4*c returns the span word of channel c. The minimum sits zero-extended in bits 15:0 and the maximum sits zero-extended in bits 31:16.
- R8: A read of 0x280 returns the live sample of channel 0 in bits 15:0 and the live sample of channel 1 in bits 31:16. A read of 0x284 returns channels 2 and 3 in the same layout. Each value is zero-extended.
- R9: Channels numbered `NUM_CH` or above read as zero in their live, minimum and maximum fields.
- R10: Reads of any other offset, including 0x28C, return 0. Writes to any offset other than 0x28C have no effect. Offset decoding ignores `paddr[1:0]`.
- R11: `pready` is high in exactly the cycle after each setup phase (`psel`=1, `penable`=0), and `pslverr` is always 0. Read data shows the state and samples present at the setup-phase clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, one cycle after setup |
| pslverr | output | 1 | APB error, always 0 |
| smp_in | input | NUM_CH*SMP_W | Live samples, channel c at bits c*SMP_W upward |

## Verification
The bench builds two copies of the block on the same bus and the same sample stream. The first copy is unsigned with four channels. The second is signed with two channels, so its channels 2 and 3 read as zero. Because the same random samples and the boundary codes 14'h0000, 14'h1FFF, 14'h2000 and 14'h3FFF feed both copies, the two orderings produce visibly different spans. A behavioural model predicts every read word, including reads after a clear in the middle of a run, a clear with bit 0 low, and writes to read-only offsets.

// File: rtl/span_pkg.sv
package span_pkg;

  // Number of channel slots in the register map.
  localparam int unsigned MAX_CH = 4;
  // Width of one half of a status word.
  localparam int unsigned HALF_W = 16;
  // Width of the decoded word index (byte address bits 11:2).
  localparam int unsigned WIDX_W = 10;

  // Word indices (byte offset divided by four).
  localparam logic [WIDX_W-1:0] WI_LIVE_LO = 10'h0A0;  // 0x280
  localparam logic [WIDX_W-1:0] WI_LIVE_HI = 10'h0A1;  // 0x284
  localparam logic [WIDX_W-1:0] WI_CLEAR   = 10'h0A3;  // 0x28C
  localparam logic [WIDX_W-1:0] WI_SPAN0   = 10'h0A4;  // 0x290

  typedef logic [2*HALF_W-1:0] word_t;

  function automatic word_t pack_halves(input logic [HALF_W-1:0] lo,
                                        input logic [HALF_W-1:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/span_rst_sync.sv
module span_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sn = out_q;

endmodule

// File: rtl/span_track.sv
module span_track #(
  parameter int unsigned SMP_W      = 14,
  parameter bit          SIGNED_CMP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed,
  input  logic [SMP_W-1:0] smp,
  output logic [SMP_W-1:0] lo_q,
  output logic [SMP_W-1:0] hi_q
);

  logic             below_lo;
  logic             above_hi;
  logic             lo_en;
  logic             hi_en;
  logic [SMP_W-1:0] lo_d;
  logic [SMP_W-1:0] hi_d;

  // Ordering of samples, chosen at build time.
  generate
    if (SIGNED_CMP) begin : g_signed
      assign below_lo = $signed(smp) < $signed(lo_q);
      assign above_hi = $signed(hi_q) < $signed(smp);
    end else begin : g_unsigned
      assign below_lo = smp < lo_q;
      assign above_hi = hi_q < smp;
    end
  endgenerate

  always_comb begin
    lo_en = seed | below_lo;
    hi_en = seed | above_hi;
    lo_d  = smp;
    hi_d  = smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_en) lo_q <= lo_d;
      if (hi_en) hi_q <= hi_d;
    end
  end

endmodule

// File: rtl/span_apb.sv
module span_apb
  import span_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SMP_W  = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [ADDR_W-1:0]       paddr,
  input  logic [31:0]             pwdata,
  input  logic [MAX_CH*SMP_W-1:0] live_all,
  input  logic [MAX_CH*SMP_W-1:0] lo_all,
  input  logic [MAX_CH*SMP_W-1:0] hi_all,
  output logic [31:0]             prdata,
  output logic                    pready,
  output logic                    clr_q
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             setup;
  logic [IDX_W-1:0] widx;
  word_t            rd_word;
  logic             clr_d;
  logic             rdy_d;
  logic             prdata_en;
  word_t            prdata_d;
  word_t            prdata_q;
  logic             rdy_q;
  logic             unused_bits;

  assign unused_bits = ^{pwdata[31:1], paddr[1:0]};

  always_comb begin
    setup = psel & ~penable;
    widx  = paddr[ADDR_W-1:2];
  end

  // Read word selection.
  always_comb begin
    rd_word = '0;
    if (widx == IDX_W'(WI_LIVE_LO)) begin
      rd_word = pack_halves(HALF_W'(live_all[0*SMP_W +: SMP_W]),
                            HALF_W'(live_all[1*SMP_W +: SMP_W]));
    end else if (widx == IDX_W'(WI_LIVE_HI)) begin
      rd_word = pack_halves(HALF_W'(live_all[2*SMP_W +: SMP_W]),
                            HALF_W'(live_all[3*SMP_W +: SMP_W]));
    end else begin
      for (int c = 0; c < MAX_CH; c++) begin
        if (widx == IDX_W'(WI_SPAN0) + IDX_W'(c)) begin
          rd_word = pack_halves(HALF_W'(lo_all[c*SMP_W +: SMP_W]),
                                HALF_W'(hi_all[c*SMP_W +: SMP_W]));
        end
      end
    end
  end

  // Next-state logic.
  always_comb begin
    rdy_d     = setup;
    clr_d     = setup & pwrite & (widx == IDX_W'(WI_CLEAR)) & pwdata[0];
    prdata_en = setup;
    prdata_d  = pwrite ? '0 : rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      clr_q    <= 1'b0;
      prdata_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      clr_q <= clr_d;
      if (prdata_en) prdata_q <= prdata_d;
    end
  end

  assign pready = rdy_q;
  assign prdata = prdata_q;

endmodule

// File: rtl/span_watch.sv
module span_watch
  import span_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned SMP_W      = 14,
  parameter bit          SIGNED_CMP = 1'b0,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [ADDR_W-1:0]       paddr,
  input  logic [31:0]             pwdata,
  output logic [31:0]             prdata,
  output logic                    pready,
  output logic                    pslverr,
  input  logic [NUM_CH*SMP_W-1:0] smp_in
);

  localparam int unsigned ALL_W = MAX_CH * SMP_W;

  logic             rst_sn;
  logic             init_q;
  logic             init_d;
  logic             clr_q;
  logic             seed;
  logic [ALL_W-1:0] live_all;
  logic [ALL_W-1:0] lo_all;
  logic [ALL_W-1:0] hi_all;

  span_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  // First-edge seeding after reset release.
  always_comb init_d = 1'b0;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) init_q <= 1'b1;
    else         init_q <= init_d;
  end

  assign seed = init_q | clr_q;

  generate
    for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
      if (c < NUM_CH) begin : g_on
        assign live_all[c*SMP_W +: SMP_W] = smp_in[c*SMP_W +: SMP_W];
        span_track #(
          .SMP_W      (SMP_W),
          .SIGNED_CMP (SIGNED_CMP)
        ) u_track (
          .clk   (clk),
          .rst_n (rst_sn),
          .seed  (seed),
          .smp   (smp_in[c*SMP_W +: SMP_W]),
          .lo_q  (lo_all[c*SMP_W +: SMP_W]),
          .hi_q  (hi_all[c*SMP_W +: SMP_W])
        );
      end else begin : g_off
        assign live_all[c*SMP_W +: SMP_W] = '0;
        assign lo_all[c*SMP_W +: SMP_W]   = '0;
        assign hi_all[c*SMP_W +: SMP_W]   = '0;
      end
    end
  endgenerate

  span_apb #(
    .ADDR_W (ADDR_W),
    .SMP_W  (SMP_W)
  ) u_bus (
    .clk      (clk),
    .rst_n    (rst_sn),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .live_all (live_all),
    .lo_all   (lo_all),
    .hi_all   (hi_all),
    .prdata   (prdata),
    .pready   (pready),
    .clr_q    (clr_q)
  );

  assign pslverr = 1'b0;

endmodule

// File: rtl/span_chk.sv
module span_chk #(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned SMP_W      = 14,
  parameter bit          SIGNED_CMP = 1'b0
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              psel,
  input logic                              penable,
  input logic                              pready,
  input logic                              seed,
  input logic                              clr,
  input logic [span_pkg::MAX_CH*SMP_W-1:0] live_all,
  input logic [span_pkg::MAX_CH*SMP_W-1:0] lo_all,
  input logic [span_pkg::MAX_CH*SMP_W-1:0] hi_all
);

  function automatic logic ord_lt(input logic [SMP_W-1:0] a,
                                  input logic [SMP_W-1:0] b);
    return SIGNED_CMP ? ($signed(a) < $signed(b)) : (a < b);
  endfunction

  assert_ready_after_setup_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> pready);

  assert_ready_only_after_setup_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pready |-> $past(psel && !penable));

  assert_clear_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !clr);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      assert_seed_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> (lo_all[c*SMP_W +: SMP_W] == $past(live_all[c*SMP_W +: SMP_W]))
              && (hi_all[c*SMP_W +: SMP_W] == $past(live_all[c*SMP_W +: SMP_W])));

      assert_min_not_above_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ord_lt(hi_all[c*SMP_W +: SMP_W], lo_all[c*SMP_W +: SMP_W]));

      assert_min_never_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !seed |=> !ord_lt($past(lo_all[c*SMP_W +: SMP_W]), lo_all[c*SMP_W +: SMP_W]));

      assert_max_never_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !seed |=> !ord_lt(hi_all[c*SMP_W +: SMP_W], $past(hi_all[c*SMP_W +: SMP_W])));
    end
  endgenerate

endmodule

bind span_watch span_chk #(
  .NUM_CH     (NUM_CH),
  .SMP_W      (SMP_W),
  .SIGNED_CMP (SIGNED_CMP)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_sn),
  .psel     (psel),
  .penable  (penable),
  .pready   (pready),
  .seed     (seed),
  .clr      (clr_q),
  .live_all (live_all),
  .lo_all   (lo_all),
  .hi_all   (hi_all)
);

// File: tb/span_watch_tb_top.sv
`timescale 1ns/1ps
module span_watch_tb_top;

  localparam int SW = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [4*SW-1:0] smp = '0;

  logic [31:0] prdata_u, prdata_s;
  logic        pready_u, pready_s, pslverr_u, pslverr_s;

  int total = 0;
  int bad = 0;
  int mode = 0;   // 0 hold, 1 random, 2 boundary codes
  string cur_req = "R1";

  always #2 clk = ~clk;

  span_watch #(.NUM_CH(4), .SMP_W(SW), .SIGNED_CMP(1'b0), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_u), .pready(pready_u),
    .pslverr(pslverr_u), .smp_in(smp));

  span_watch #(.NUM_CH(2), .SMP_W(SW), .SIGNED_CMP(1'b1), .ADDR_W(12)) dut_s (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_s), .pready(pready_s),
    .pslverr(pslverr_s), .smp_in(smp[2*SW-1:0]));

  // ---------------- reference model ----------------
  logic [SW-1:0] mu [4];
  logic [SW-1:0] xu [4];
  logic [SW-1:0] ms [2];
  logic [SW-1:0] xs [2];
  bit clr_pend = 0;
  bit exp_rdy = 0;
  bit exp_rd = 0;
  logic [31:0] exp_u = '0, exp_s = '0;
  logic [11:0] exp_addr = '0;

  function automatic bit lt(input logic [SW-1:0] a, input logic [SW-1:0] b, input bit sg);
    if (sg) return $signed(a) < $signed(b);
    return a < b;
  endfunction

  function automatic logic [SW-1:0] live(input int c, input bit sg);
    int n = sg ? 2 : 4;
    if (c >= n) return '0;
    return smp[c*SW +: SW];
  endfunction

  function automatic logic [31:0] expw(input logic [11:0] a, input bit sg);
    logic [9:0] w = a[11:2];
    logic [15:0] lo = 16'h0, hi = 16'h0;
    int c;
    if (w == 10'h0A0) begin lo = 16'(live(0, sg)); hi = 16'(live(1, sg)); end
    else if (w == 10'h0A1) begin lo = 16'(live(2, sg)); hi = 16'(live(3, sg)); end
    else if (w >= 10'h0A4 && w <= 10'h0A7) begin
      c = int'(w - 10'h0A4);
      if (!sg) begin lo = 16'(mu[c]); hi = 16'(xu[c]); end
      else if (c < 2) begin lo = 16'(ms[c]); hi = 16'(xs[c]); end
    end
    return {hi, lo};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin mu[c] = smp[c*SW +: SW]; xu[c] = smp[c*SW +: SW]; end
      for (int c = 0; c < 2; c++) begin ms[c] = smp[c*SW +: SW]; xs[c] = smp[c*SW +: SW]; end
      clr_pend = 0; exp_rdy = 0; exp_rd = 0;
    end else begin
      exp_rdy = psel && !penable;
      exp_rd  = psel && !penable && !pwrite;
      if (exp_rd) begin
        exp_u = expw(paddr, 1'b0);
        exp_s = expw(paddr, 1'b1);
        exp_addr = paddr;
      end
      for (int c = 0; c < 4; c++) begin
        if (clr_pend) begin mu[c] = smp[c*SW +: SW]; xu[c] = smp[c*SW +: SW]; end
        else begin
          if (lt(smp[c*SW +: SW], mu[c], 1'b0)) mu[c] = smp[c*SW +: SW];
          if (lt(xu[c], smp[c*SW +: SW], 1'b0)) xu[c] = smp[c*SW +: SW];
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (clr_pend) begin ms[c] = smp[c*SW +: SW]; xs[c] = smp[c*SW +: SW]; end
        else begin
          if (lt(smp[c*SW +: SW], ms[c], 1'b1)) ms[c] = smp[c*SW +: SW];
          if (lt(xs[c], smp[c*SW +: SW], 1'b1)) xs[c] = smp[c*SW +: SW];
        end
      end
      clr_pend = psel && !penable && pwrite && (paddr[11:2] == 10'h0A3) && pwdata[0];
    end
  end

  function automatic string addr_req(input logic [11:0] a);
    if (a[11:2] == 10'h0A0 || a[11:2] == 10'h0A1) return "R8";
    if (a[11:2] >= 10'h0A4 && a[11:2] <= 10'h0A7) return "R3 R4 R7";
    return "R10";
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      check("R11 pready unsigned", {31'h0, pready_u}, {31'h0, exp_rdy});
      check("R11 pready signed", {31'h0, pready_s}, {31'h0, exp_rdy});
      if (exp_rdy) begin
        check("R11 pslverr", {30'h0, pslverr_u, pslverr_s}, 32'h0);
      end
      if (exp_rdy && exp_rd) begin
        check({cur_req, " ", addr_req(exp_addr), " unsigned"}, prdata_u, exp_u);
        check({cur_req, " ", addr_req(exp_addr), " signed"}, prdata_s, exp_s);
      end
    end
  end

  // ---------------- sample driver ----------------
  function automatic logic [SW-1:0] edge_code(input int k);
    case (k)
      0: return 14'h0000;
      1: return 14'h3FFF;
      2: return 14'h2000;
      default: return 14'h1FFF;
    endcase
  endfunction

  always @(negedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (mode == 1) smp[c*SW +: SW] <= SW'($urandom);
      else if (mode == 2) smp[c*SW +: SW] <= edge_code(int'($urandom % 4));
    end
  end

  // ---------------- bus tasks ----------------
  task automatic xfer(input logic [11:0] a, input bit wr, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic read_all();
    xfer(12'h280, 1'b0, 32'h0);
    xfer(12'h284, 1'b0, 32'h0);
    for (int c = 0; c < 4; c++) xfer(12'h290 + 12'(4*c), 1'b0, 32'h0);
  endtask

  task automatic run_reads(input int n);
    for (int i = 0; i < n; i++) begin
      if (i % 5 == 4) xfer(12'h280 + 12'(4*(i % 2)), 1'b0, 32'h0);
      else xfer(12'h290 + 12'(4*(i % 4)), 1'b0, 32'h0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- sequence ----------------
  initial begin
    smp = {14'h3001, 14'h0123, 14'h2A5C, 14'h0A5C};
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1 pready in reset", {30'h0, pready_u, pready_s}, 32'h0);
    check("R1 prdata unsigned in reset", prdata_u, 32'h0);
    check("R1 prdata signed in reset", prdata_s, 32'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    cur_req = "R2 R9";
    read_all();

    cur_req = "R3 R4";
    mode = 1;
    run_reads(150);

    cur_req = "R5";
    xfer(12'h28C, 1'b1, 32'h0000_0001);
    read_all();
    run_reads(100);

    cur_req = "R6";
    xfer(12'h28C, 1'b1, 32'hFFFF_FFFE);
    run_reads(40);

    cur_req = "R10";
    xfer(12'h290, 1'b1, 32'hFFFF_FFFF);
    xfer(12'h280, 1'b1, 32'h0000_0001);
    xfer(12'h294, 1'b1, 32'h0000_0001);
    read_all();
    xfer(12'h2A0, 1'b0, 32'h0);
    xfer(12'h000, 1'b0, 32'h0);
    xfer(12'h288, 1'b0, 32'h0);
    xfer(12'h28C, 1'b0, 32'h0);
    xfer(12'h293, 1'b0, 32'h0);

    cur_req = "R4 R5";
    mode = 2;
    xfer(12'h28C, 1'b1, 32'h0000_0001);
    run_reads(150);

    cur_req = "R3";
    mode = 0;
    run_reads(20);

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule